// File: doc/BRIEF.md
# Periodic Serial ADC Acquisition Controller

This block is the host-side master for a serial analog-to-digital converter that is read after each conversion finishes. A free-running timer fires once every `period_i` system clocks. When the controller is idle, each timer event starts a conversion: it drives an active-low start pulse of fixed width to the converter. It then watches the converter's busy line. When that line goes low, the result is ready, and the controller lowers chip select and clocks in a 24-bit frame over SPI.

The SPI master idles its clock low and samples the data line on the falling (trailing) edge of each clock pulse. The first 18 bits received, most significant first, form the sample. The last six are dropped. The sample is presented together with a one-cycle valid strobe in the same cycle that chip select is released.

A timer event that arrives while a conversion or read is still running does not start anything. It only advances a wrapping overrun counter. The serial clock is divided down from the system clock. A divide setting that would push it above the converter's 17 MHz limit is rejected when the design is elaborated.

Top module: `adc_acq_ctrl`

## Requirements
- R1: While reset is asserted, the outputs hold these values: `cnv_n_o`=1, `cs_n_o`=1, `sclk_o`=0, `sample_vld_o`=0 and `overrun_cnt_o`=0.
- R2: With `period_i`=P≥1, timer events occur every P system clocks, so any two conversion starts are a whole multiple of P clocks apart. With `period_i`=0, no conversion is ever started.
- R3: Each accepted timer event produces exactly one low pulse on `cnv_n_o`, lasting `CNV_W` clocks. The start pulse is never low while `cs_n_o` is low.
- R4: `cs_n_o` falls on the first clock edge after `busy_i` is seen falling, and never before the converter has signalled end of conversion.
- R5: During each read, `sclk_o` produces exactly 24 pulses. Each high phase and each low phase lasts `SCLK_DIV` clocks. `sclk_o` is low whenever `cs_n_o` is high, and `miso_i` is sampled as `sclk_o` falls.
- R6: `sample_o` equals the first 18 received bits: the first bit received is bit 17 and the eighteenth is bit 0. Received bits 19 to 24 have no effect on the output.
- R7: `sample_vld_o` is high for exactly one clock per read. That clock is the one in which `cs_n_o` returns high.
- R8: A timer event that arrives while the controller is not idle starts no conversion and increments `overrun_cnt_o` by one, modulo 2^`OVR_W`.
- R9: The serial clock rate, `SYS_HZ`/(2·`SCLK_DIV`), never exceeds `SCLK_MAX_HZ`. A parameter set that violates this limit is flagged at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | PER_W | Timer period in clocks; 0 stops the timer |
| cnv_n_o | output | 1 | Active-low conversion start pulse |
| busy_i | input | 1 | Converter busy; falling edge marks end of conversion |
| cs_n_o | output | 1 | SPI chip select, active low |
| sclk_o | output | 1 | SPI clock, idle low |
| miso_i | input | 1 | SPI serial data from the converter |
| sample_o | output | SAMPLE_BITS | Last assembled sample |
| sample_vld_o | output | 1 | One-cycle strobe marking a new sample |
| overrun_cnt_o | output | OVR_W | Wrapping count of ignored timer events |

## Verification
The assertions check the following on every clock:
- the start pulse and chip select are mutually exclusive;
- the serial clock stays low outside a read;
- chip select drops only after busy has fallen;
- the valid strobe coincides with chip select rising;
- the overrun counter only ever steps by one;
- back-to-back timer events occur only for a period of one.

Other behaviour can only be shown by the bench's scenarios, which pair a converter model with a scoreboard of expected samples:
- the 18-of-24 bit extraction and its bit order;
- the exact widths of the start pulse and of the clock phases;
- the pulse count per frame;
- the exact number of overruns, which follows from the spacing of conversion starts at periods shorter than, equal to one, and longer than a full acquisition.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_READ
    } acq_state_e;

endpackage

// File: rtl/acq_timer.sv
module acq_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic tick;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (period_i != '0) && (tmr_q.cnt >= period_i - 1'b1);
        if (tick || period_i == '0) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tick_o = tick;

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && period_i > 1) |=> (!tick_o || period_i == 1))
        else $error("timer fired on consecutive clocks with period above one");

endmodule

// File: rtl/acq_spi_rx.sv
module acq_spi_rx #(
    parameter int DIV  = 3,
    parameter int BITS = 24,
    parameter int KEEP = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            miso_i,
    output logic            sclk_o,
    output logic            done_o,
    output logic [KEEP-1:0] data_o
);

    localparam int DIV_W = $clog2(DIV + 1);
    localparam int CNT_W = $clog2(BITS + 1);

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] bits;
        logic [BITS-1:0]  sh;
        logic             done;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        if (start_i && !rx_q.active) begin
            rx_d.active = 1'b1;
            rx_d.sclk   = 1'b0;
            rx_d.div    = '0;
            rx_d.bits   = '0;
        end else if (rx_q.active) begin
            if (rx_q.div == DIV_W'(DIV - 1)) begin
                rx_d.div  = '0;
                rx_d.sclk = ~rx_q.sclk;
                if (rx_q.sclk) begin
                    rx_d.sh   = {rx_q.sh[BITS-2:0], miso_i};
                    rx_d.bits = rx_q.bits + 1'b1;
                    if (rx_q.bits == CNT_W'(BITS - 1)) begin
                        rx_d.active = 1'b0;
                        rx_d.done   = 1'b1;
                    end
                end
            end else begin
                rx_d.div = rx_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign sclk_o = rx_q.sclk;
    assign done_o = rx_q.done;
    assign data_o = rx_q.sh[BITS-1 -: KEEP];

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_q.active |-> !rx_q.sclk)
        else $error("serial clock high outside a transfer");

    // R7
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.done |-> ($past(rx_q.active) && !rx_q.active && !rx_q.sclk))
        else $error("frame completion without a running transfer");

endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl #(
    parameter int SYS_HZ      = 100_000_000,
    parameter int SCLK_MAX_HZ = 17_000_000,
    parameter int SCLK_DIV    = 3,
    parameter int PER_W       = 16,
    parameter int CNV_W       = 3,
    parameter int FRAME_BITS  = 24,
    parameter int SAMPLE_BITS = 18,
    parameter int OVR_W       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PER_W-1:0]       period_i,
    output logic                   cnv_n_o,
    input  logic                   busy_i,
    output logic                   cs_n_o,
    output logic                   sclk_o,
    input  logic                   miso_i,
    output logic [SAMPLE_BITS-1:0] sample_o,
    output logic                   sample_vld_o,
    output logic [OVR_W-1:0]       overrun_cnt_o
);
    import adc_acq_pkg::*;

    localparam int CNV_CW = $clog2(CNV_W + 1);

    typedef struct packed {
        acq_state_e             state;
        logic [CNV_CW-1:0]      cnv_cnt;
        logic                   busy_r;
        logic [SAMPLE_BITS-1:0] sample;
        logic                   vld;
        logic [OVR_W-1:0]       ovr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tick;
    logic spi_start;
    logic spi_done;
    logic spi_sclk;
    logic [SAMPLE_BITS-1:0] spi_data;
    logic busy_fall;

    // R9
    initial begin
        rate_limit_chk: assert (longint'(SYS_HZ) <= 2 * longint'(SCLK_DIV) * longint'(SCLK_MAX_HZ))
            else $error("SCLK_DIV gives a serial clock above the converter limit");
    end

    acq_timer #(.PER_W(PER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .tick_o   (tick)
    );

    acq_spi_rx #(.DIV(SCLK_DIV), .BITS(FRAME_BITS), .KEEP(SAMPLE_BITS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (spi_start),
        .miso_i  (miso_i),
        .sclk_o  (spi_sclk),
        .done_o  (spi_done),
        .data_o  (spi_data)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.vld    = 1'b0;
        ctl_d.busy_r = busy_i;
        spi_start    = 1'b0;
        busy_fall    = ctl_q.busy_r && !busy_i;

        if (tick && ctl_q.state != ST_IDLE) begin
            ctl_d.ovr = ctl_q.ovr + 1'b1;
        end

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (tick) begin
                    ctl_d.state   = ST_CONV;
                    ctl_d.cnv_cnt = '0;
                end
            end
            ST_CONV: begin
                if (ctl_q.cnv_cnt == CNV_CW'(CNV_W - 1)) begin
                    ctl_d.state = ST_WAIT;
                end else begin
                    ctl_d.cnv_cnt = ctl_q.cnv_cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (busy_fall) begin
                    spi_start   = 1'b1;
                    ctl_d.state = ST_READ;
                end
            end
            ST_READ: begin
                if (spi_done) begin
                    ctl_d.state  = ST_IDLE;
                    ctl_d.sample = spi_data;
                    ctl_d.vld    = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cnv_n_o       = (ctl_q.state != ST_CONV);
    assign cs_n_o        = (ctl_q.state != ST_READ);
    assign sclk_o        = spi_sclk;
    assign sample_o      = ctl_q.sample;
    assign sample_vld_o  = ctl_q.vld;
    assign overrun_cnt_o = ctl_q.ovr;

    // R3
    cnv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_n_o |-> cs_n_o)
        else $error("start pulse overlaps a read");

    // R4
    cs_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !$past(busy_i))
        else $error("chip select lowered before end of conversion");

    // R5
    sclk_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o)
        else $error("serial clock active with chip select high");

    // R7
    vld_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> (cs_n_o && !$past(cs_n_o)))
        else $error("valid strobe not aligned with chip select release");

    // R8
    ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(overrun_cnt_o) |-> (overrun_cnt_o == OVR_W'($past(overrun_cnt_o) + 1'b1)))
        else $error("overrun counter jumped");

endmodule

// File: tb/adc_acq_ctrl_test.sv
module adc_acq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int SYS_HZ     = 100_000_000;
    localparam int MAX_HZ     = 17_000_000;
    localparam int DIV        = 3;
    localparam int CNV_W      = 3;
    localparam int PER_W      = 16;
    localparam int CONV_T     = 20;

    logic        clk;
    logic        rst_n;
    logic [15:0] period;
    logic        cnv_n;
    logic        busy;
    logic        cs_n;
    logic        sclk;
    logic        miso;
    logic [17:0] sample;
    logic        vld;
    logic [7:0]  ovr;

    adc_acq_ctrl #(
        .SYS_HZ(SYS_HZ), .SCLK_MAX_HZ(MAX_HZ), .SCLK_DIV(DIV), .PER_W(PER_W),
        .CNV_W(CNV_W), .FRAME_BITS(24), .SAMPLE_BITS(18), .OVR_W(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .period_i(period), .cnv_n_o(cnv_n),
        .busy_i(busy), .cs_n_o(cs_n), .sclk_o(sclk), .miso_i(miso),
        .sample_o(sample), .sample_vld_o(vld), .overrun_cnt_o(ovr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [23:0] tx_q[$];
    logic [17:0] exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_word(input logic [23:0] w);
        tx_q.push_back(w);
        exp_q.push_back(w[23:6]);
    endtask

    // monitor and converter model
    logic        prev_cnv = 1'b1, prev_cs = 1'b1, prev_sclk = 1'b0;
    int          cnv_low = 0, cnv_falls = 0, last_fall = 0, busy_cnt = 0;
    int          busy_fall_cyc = 0, rise_cnt = 0, hi_run = 0, bit_idx = 0, vld_cnt = 0;
    int          exp_ovr = 0;
    bit          have_last = 0;
    logic [23:0] cur_word = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            busy = 1'b0;
            miso = 1'b0;
        end else begin
            if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                    busy = 1'b0;
                    busy_fall_cyc = cyc;
                end
            end
            if (!cnv_n) cnv_low++;
            if (prev_cnv && !cnv_n) begin
                cnv_falls++;
                if (have_last && period != 0) begin
                    int gap;
                    gap = cyc - last_fall;
                    // R2: starts spaced by a whole number of periods
                    check(gap % int'(period) == 0, "R2", "start spacing", gap, int'(period));
                    exp_ovr += gap / int'(period) - 1;
                end
                last_fall = cyc;
                have_last = 1;
                busy = 1'b1;
                busy_cnt = CONV_T;
            end
            if (!prev_cnv && cnv_n) begin
                check(cnv_low == CNV_W, "R3", "start pulse width", cnv_low, CNV_W);
                cnv_low = 0;
            end
            if (prev_cs && !cs_n) begin
                check(cyc - busy_fall_cyc == 1, "R4", "cs delay after busy fall",
                      cyc - busy_fall_cyc, 1);
                rise_cnt = 0;
                bit_idx  = 0;
                cur_word = (tx_q.size() > 0) ? tx_q.pop_front() : 24'h0;
            end
            if (!prev_cs && cs_n) begin
                check(rise_cnt == 24, "R5", "clock pulses per frame", rise_cnt, 24);
            end
            if (sclk) hi_run++;
            if (!prev_sclk && sclk) begin
                rise_cnt++;
                if (bit_idx < 24) begin
                    miso = cur_word[23 - bit_idx];
                    bit_idx++;
                end
            end
            if (prev_sclk && !sclk) begin
                check(hi_run == DIV, "R5", "clock high phase", hi_run, DIV);
                check(longint'(SYS_HZ) <= 2 * longint'(hi_run) * longint'(MAX_HZ),
                      "R9", "clock rate bound", hi_run, DIV);
                hi_run = 0;
            end
            if (vld) begin
                vld_cnt++;
                check(cs_n && !prev_cs, "R7", "strobe at cs release", int'(cs_n), 1);
                if (exp_q.size() == 0) begin
                    check(0, "R6", "unexpected sample", longint'(sample), -1);
                end else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    check(sample == e, "R6", "sample value", longint'(sample), longint'(e));
                end
            end
            prev_cnv  = cnv_n;
            prev_cs   = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic run_phase(input int p, input int n);
        int base_falls;
        int base_vld;
        base_falls = cnv_falls;
        base_vld   = vld_cnt;
        have_last  = 0;
        @(negedge clk); #1;
        period = 16'(p);
        while (cnv_falls < base_falls + n) begin
            @(negedge clk); #1;
        end
        period = '0;
        while (vld_cnt < base_vld + n) begin
            @(negedge clk); #1;
        end
        repeat (5) @(negedge clk);
        #1;
        // R8: ignored events counted, none started
        check(ovr == 8'(exp_ovr), "R8", "overrun count", ovr, 8'(exp_ovr));
        check(cnv_falls == base_falls + n, "R8", "conversions started", cnv_falls, base_falls + n);
    endtask

    initial begin
        rst_n  = 1'b0;
        period = '0;
        repeat (4) @(negedge clk);
        #1;
        check(cnv_n == 1'b1, "R1", "cnv_n in reset", cnv_n, 1);
        check(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        check(vld == 1'b0, "R1", "valid in reset", vld, 0);
        check(ovr == 8'd0, "R1", "overrun in reset", ovr, 0);
        rst_n = 1'b1;

        // R2: period zero never starts a conversion
        repeat (300) @(negedge clk);
        #1;
        check(cnv_falls == 0, "R2", "starts with period zero", cnv_falls, 0);

        // long period: no overruns expected
        push_word(24'hABCDEF);
        push_word(24'h000000);
        push_word(24'hFFFFFF);
        push_word(24'h80003F);
        run_phase(200, 4);
        check(exp_ovr == 0, "R8", "no overrun at long period", exp_ovr, 0);

        // short period: events land during reads
        begin
            logic [23:0] lfsr;
            lfsr = 24'h1ACE5;
            for (int i = 0; i < 5; i++) begin
                lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
                lfsr = lfsr ^ (lfsr << 7);
                push_word(lfsr);
            end
        end
        run_phase(60, 5);
        check(exp_ovr > 0, "R8", "overruns at short period", exp_ovr, 1);

        // period of one: every clock is an event
        push_word(24'h5A5A5A);
        push_word(24'hA5A5A5);
        push_word(24'h00FFC0);
        run_phase(1, 3);

        check(exp_q.size() == 0, "R6", "samples left over", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule